// File: doc/BRIEF.md
# Configurable Routing I/O Cell

This block is one pin-side cell of a signal-routing fabric. A static configuration word sets its behaviour. A dynamic four-way selector chooses one of four data inputs under control of two select lines. Each select line comes from one of two select pins and has its own inversion. A single storage element follows. It can act as an edge-triggered register or as a transparent-high latch, and it sits in one of two places: between the selector and the pin driver, or between the pin input and the cell's routing-side output. It can also be left out of the outgoing path entirely.

The pin is modelled as three signals: the level coming in, the level driven out, and the driver enable. At the output stage the value can be inverted, replaced by a constant level, or converted into open-drain signalling. The enable has its own polarity and is held off while a power-up indication is present. Clock and clock enable also have their own polarity settings, and a synchronous reset clears the storage element.

Top module: `route_io_cell`

## Requirements
- R1: The effective select code {s1,s0} picks a data input in Gray order: 00 picks dataIn[0], 01 picks dataIn[1], 11 picks dataIn[2], 10 picks dataIn[3].
- R2: Effective select line s0 comes from selA when cfg[0]=0 and from selB when cfg[0]=1, and is inverted when cfg[2]=1. Line s1 is set the same way by cfg[1] (source) and cfg[3] (inversion).
- R3: With cfg[8]=0, or with cfg[9]=1, the selected data reaches padOut combinationally in the same cycle.
- R4: With cfg[8]=1, cfg[9]=0 and cfg[10]=0, padOut shows a register. The register loads the selected data on each rising edge of the effective clock, which is clkIn XOR cfg[5].
- R5: When the effective clock enable (clkEnIn XOR cfg[6]) is 0, the storage element keeps its value through clock edges and transparent phases.
- R6: With cfg[10]=1, the storage element is a latch. It follows its input while the effective clock is high and holds its value while the clock is low.
- R7: While rst is high, the storage element clears to 0 at an effective clock edge (register) or during the transparent phase (latch). Reset overrides the clock enable.
- R8: With cfg[8]=1 and cfg[9]=1, the storage element loads padIn and drives routeOut. In every other setting, routeOut equals padIn.
- R9: cfg[7]=1 inverts the data value on its way to the pin.
- R10: With cfg[11]=1, the pin value equals cfg[12], whatever the data, select and storage state.
- R11: padOe equals (oeIn XOR cfg[4]) AND NOT pwrUp, except where open-drain mode changes it.
- R12: With cfg[13]=1, padOut is always 0, and padOe is the R11 enable ANDed with the inverse of the pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg | input | 14 | Static configuration word; bit meanings as in the requirements |
| dataIn | input | 4 | Four selector data inputs |
| selA | input | 1 | First select source pin |
| selB | input | 1 | Second select source pin |
| oeIn | input | 1 | Output enable control before polarity |
| clkIn | input | 1 | Storage clock before polarity |
| clkEnIn | input | 1 | Clock enable before polarity |
| rst | input | 1 | Synchronous clear of the storage element, active high |
| pwrUp | input | 1 | Power-up indication; forces the driver off |
| padIn | input | 1 | Level seen at the pin |
| padOut | output | 1 | Level driven toward the pin |
| padOe | output | 1 | Pin driver enable |
| routeOut | output | 1 | Routing-side output of the cell |

## Verification
Several rules are checked by the assertions on every edge: the power-up gating of the driver enable, the agreement of the enable with its polarity-adjusted control, the fact that open-drain mode never drives high, and the fact that the register holds its value whenever the effective clock enable is low. The Gray selection order, select sourcing, output inversion, fixed levels, latch transparency, reset clearing, and the input-path routing of the storage element can only be shown by the bench's scenarios. The bench exercises these under many random configuration words and compares each result against its own model.

// File: rtl/rioc_pkg.sv
`timescale 1ns/1ps
package rioc_pkg;
  localparam int SEL_W = 2;
  localparam int N_IN  = 1 << SEL_W;
  localparam int CFG_W = 14;

  // configuration bit positions
  localparam int B_SRC0     = 0;   // select line i source: B_SRC0+i
  localparam int B_SINV0    = 2;   // select line i invert: B_SINV0+i
  localparam int B_OE_INV   = 4;
  localparam int B_CLK_INV  = 5;
  localparam int B_CEN_INV  = 6;
  localparam int B_OUT_INV  = 7;
  localparam int B_STORE    = 8;
  localparam int B_PATH_IN  = 9;
  localparam int B_LATCH    = 10;
  localparam int B_FIX_EN   = 11;
  localparam int B_FIX_VAL  = 12;
  localparam int B_OPEN_DR  = 13;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             clkEff;
    logic             clkEn;
    logic             oeEff;
    logic             outInv;
    logic             storeEn;
    logic             pathIn;
    logic             latchMode;
    logic             fixedEn;
    logic             fixedVal;
    logic             openDrain;
  } ctrl_t;
endpackage

// File: rtl/rioc_ctrl.sv
`timescale 1ns/1ps
module rioc_ctrl
  import rioc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             selA,
  input  logic             selB,
  input  logic             oeIn,
  input  logic             clkIn,
  input  logic             clkEnIn,
  input  logic             pwrUp,
  output ctrl_t            ctl
);
  logic [SEL_W-1:0] selEff;

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    logic srcPick;
    assign srcPick   = cfg[B_SRC0+i] ? selB : selA;
    assign selEff[i] = srcPick ^ cfg[B_SINV0+i];
  end

  always_comb begin
    ctl           = '0;
    ctl.sel       = selEff;
    ctl.clkEff    = clkIn ^ cfg[B_CLK_INV];
    ctl.clkEn     = clkEnIn ^ cfg[B_CEN_INV];
    ctl.oeEff     = (oeIn ^ cfg[B_OE_INV]) & ~pwrUp;
    ctl.outInv    = cfg[B_OUT_INV];
    ctl.storeEn   = cfg[B_STORE];
    ctl.pathIn    = cfg[B_PATH_IN];
    ctl.latchMode = cfg[B_LATCH];
    ctl.fixedEn   = cfg[B_FIX_EN];
    ctl.fixedVal  = cfg[B_FIX_VAL];
    ctl.openDrain = cfg[B_OPEN_DR];
  end
endmodule

// File: rtl/rioc_datapath.sv
`timescale 1ns/1ps
module rioc_datapath
  import rioc_pkg::*;
(
  input  ctrl_t           ctl,
  input  logic            rst,
  input  logic [N_IN-1:0] dataIn,
  input  logic            padIn,
  output logic            padOut,
  output logic            padOe,
  output logic            routeOut
);
  logic [SEL_W-1:0] pickIdx;
  logic             muxOut;
  logic             stD;
  logic             regQ;
  logic             latQ;
  logic             stQ;
  logic             dataVal;
  logic             pinVal;

  // Gray select code to binary index
  always_comb begin
    pickIdx[SEL_W-1] = ctl.sel[SEL_W-1];
    for (int i = SEL_W - 2; i >= 0; i--) begin
      pickIdx[i] = pickIdx[i+1] ^ ctl.sel[i];
    end
  end

  assign muxOut = dataIn[pickIdx];
  assign stD    = ctl.pathIn ? padIn : muxOut;

  always_ff @(posedge ctl.clkEff) begin
    if (rst)            regQ <= 1'b0;
    else if (ctl.clkEn) regQ <= stD;
  end

  always_latch begin
    if (ctl.clkEff) begin
      if (rst)            latQ = 1'b0;
      else if (ctl.clkEn) latQ = stD;
    end
  end

  assign stQ = ctl.latchMode ? latQ : regQ;

  always_comb begin
    dataVal = (ctl.storeEn && !ctl.pathIn) ? stQ : muxOut;
    pinVal  = ctl.fixedEn ? ctl.fixedVal : (dataVal ^ ctl.outInv);
    if (ctl.openDrain) begin
      padOut = 1'b0;
      padOe  = ctl.oeEff & ~pinVal;
    end else begin
      padOut = pinVal;
      padOe  = ctl.oeEff;
    end
    routeOut = (ctl.storeEn && ctl.pathIn) ? stQ : padIn;
  end

  // R5
  reg_hold_chk: assert property (@(posedge ctl.clkEff) disable iff (rst)
    !ctl.clkEn |=> $stable(regQ));

  // R12
  open_drain_low_chk: assert property (@(posedge ctl.clkEff) disable iff (rst)
    ctl.openDrain |-> !padOut);
endmodule

// File: rtl/route_io_cell.sv
`timescale 1ns/1ps
module route_io_cell
  import rioc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_IN-1:0]  dataIn,
  input  logic             selA,
  input  logic             selB,
  input  logic             oeIn,
  input  logic             clkIn,
  input  logic             clkEnIn,
  input  logic             rst,
  input  logic             pwrUp,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             routeOut
);
  ctrl_t ctl;

  rioc_ctrl u_ctrl (
    .cfg(cfg), .selA(selA), .selB(selB), .oeIn(oeIn), .clkIn(clkIn),
    .clkEnIn(clkEnIn), .pwrUp(pwrUp), .ctl(ctl)
  );

  rioc_datapath u_dp (
    .ctl(ctl), .rst(rst), .dataIn(dataIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .routeOut(routeOut)
  );

  // R11
  pwrup_oe_off_chk: assert property (@(posedge clkIn) disable iff (rst)
    pwrUp |-> !padOe);

  // R11
  oe_polarity_chk: assert property (@(posedge clkIn) disable iff (rst)
    padOe |-> (oeIn != cfg[B_OE_INV]));
endmodule

// File: tb/route_io_cell_tb.sv
`timescale 1ns/1ps
module route_io_cell_tb;
  logic [13:0] cfg = '0;
  logic [3:0]  dataIn = '0;
  logic selA = 0, selB = 0, oeIn = 0, clk = 0, clkEnIn = 1, rst = 1;
  logic pwrUp = 0, padIn = 0;
  logic padOut, padOe, routeOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic expQ = 0;

  always #2 clk = ~clk;

  route_io_cell u_dut (
    .cfg(cfg), .dataIn(dataIn), .selA(selA), .selB(selB), .oeIn(oeIn),
    .clkIn(clk), .clkEnIn(clkEnIn), .rst(rst), .pwrUp(pwrUp), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .routeOut(routeOut)
  );

  // R1 R2: Gray selection with per-line source and inversion
  function automatic logic muxExp();
    logic s0, s1;
    logic [1:0] idx;
    s0 = (cfg[0] ? selB : selA) ^ cfg[2];
    s1 = (cfg[1] ? selB : selA) ^ cfg[3];
    case ({s1, s0})
      2'b00: idx = 2'd0;
      2'b01: idx = 2'd1;
      2'b11: idx = 2'd2;
      default: idx = 2'd3;
    endcase
    return dataIn[idx];
  endfunction

  // R3 R4 R9 R10 R11 R12 R8: returns {routeOut, padOe, padOut}
  function automatic logic [2:0] outExp();
    logic d, v, oe, po, pe, ro;
    d  = (cfg[8] && !cfg[9]) ? expQ : muxExp();
    v  = cfg[11] ? cfg[12] : (d ^ cfg[7]);
    oe = (oeIn ^ cfg[4]) & ~pwrUp;
    if (cfg[13]) begin po = 1'b0; pe = oe & ~v; end
    else         begin po = v;    pe = oe;      end
    ro = (cfg[8] && cfg[9]) ? expQ : padIn;
    return {ro, pe, po};
  endfunction

  function automatic string outTag();
    if (cfg[13]) return "R12";
    if (cfg[11]) return "R10";
    if (cfg[8] && !cfg[9]) return cfg[10] ? "R6/R5/R7" : "R4/R5/R7";
    return "R1/R2/R3/R9";
  endfunction

  // R5 R7: storage model update (same rule for register edge and latch window)
  task automatic updModel();
    logic d;
    d = cfg[9] ? padIn : muxExp();
    if (rst) expQ = 1'b0;
    else if (clkEnIn ^ cfg[6]) expQ = d;
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cfg=%h actual=%b expected=%b at %0t", tag, cfg, act, exp, $time);
    end
  endtask

  task automatic doStep(input logic rstV, input logic [13:0] cfgV, input bit chk);
    logic [2:0] e;
    bit early;
    @(posedge clk);
    #0.5;
    rst     = rstV;
    cfg     = cfgV;
    dataIn  = 4'($urandom);
    selA    = 1'($urandom);
    selB    = 1'($urandom);
    oeIn    = 1'($urandom);
    padIn   = 1'($urandom);
    clkEnIn = ($urandom_range(0, 3) != 0) ^ cfgV[6];
    pwrUp   = ($urandom_range(0, 7) == 0);
    if (rstV) clkEnIn = ~cfgV[6];
    #0.5;
    early = cfgV[10] && !cfgV[5];
    if (early) updModel();
    if (chk) begin
      e = outExp();
      chk1(padOut, e[0], outTag());
      chk1(padOe, e[1], "R11/R12");
      chk1(routeOut, e[2], "R8");
    end
    if (!early) updModel();
  endtask

  task automatic runPhase(input logic [13:0] cfgV, input int n);
    doStep(1'b1, cfg, 1'b0);
    doStep(1'b1, cfgV, 1'b0);
    doStep(1'b1, cfgV, 1'b0);
    for (int i = 0; i < n; i++) doStep(1'b0, cfgV, 1'b1);
  endtask

  initial begin
    logic [13:0] dirCfg [12];
    void'($urandom(32'h5EED_0042));
    dirCfg[0]  = 14'h0000;                         // R3 plain bypass
    dirCfg[1]  = 14'h0100;                         // R4 register
    dirCfg[2]  = 14'h0120;                         // R4 inverted clock
    dirCfg[3]  = 14'h0500;                         // R6 latch
    dirCfg[4]  = 14'h0520;                         // R6 latch inverted clock
    dirCfg[5]  = 14'h0300;                         // R8 input-path register
    dirCfg[6]  = 14'h0700;                         // R8 input-path latch
    dirCfg[7]  = 14'h1800;                         // R10 fixed high
    dirCfg[8]  = 14'h0800;                         // R10 fixed low
    dirCfg[9]  = 14'h2080;                         // R12 open drain, inverted
    dirCfg[10] = 14'h000F;                         // R2 swapped, inverted selects
    dirCfg[11] = 14'h0150;                         // R5 inverted enable, R11 inverted oe
    // R7: reset state, register mode, first cycle after reset
    runPhase(14'h0100, 0);
    @(posedge clk); #0.5; rst = 0; clkEnIn = 0; cfg = 14'h0100;
    #0.5; chk1(padOut, 1'b0, "R7");
    foreach (dirCfg[k]) runPhase(dirCfg[k], 60);
    for (int p = 0; p < 30; p++) runPhase(14'($urandom), 60);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule